// File: doc/BRIEF.md
# Mixed-Width Register Access Adapter

The adapter lets a CPU bus that issues byte, halfword or longword accesses reach a register file in which each register has one fixed native width of one, two or four bytes. A constant width map assigns a native width to each aligned longword of the 512-byte register window. The adapter turns every CPU access into a short run of native-width sub-operations on a simple register port, issuing one sub-operation per clock. When the whole access has finished it pulses a completion strobe.

Three cases arise. If the access width equals the native width, a single sub-operation is issued. If the access is wider, it is split into native-width pieces at ascending addresses, with the lowest address carrying the most significant part. If the access is narrower, the adapter works on the containing register: a read extracts the addressed bytes, and a write reads the register, replaces those bytes and writes it back. Accesses that fall outside the window, land on an unused map entry, are misaligned or carry an invalid size code finish at once with an error flag and touch nothing.

Top module: `reg_width_adapter`

## Requirements
- R1: An offset with bit 9 set (0x200 to 0x3FF) ends the access with `rspErr` high and no register sub-operation. A write to such an offset leaves every register unchanged.
- R2: The native width comes from map entry offset[8:2], two bits per entry (entry i at bits 2i+1:2i): 1 means byte, 2 halfword, 3 longword and 0 unused. An access to an unused entry is an error. The default map gives entries 0-7 byte, 8-15 halfword, 16-23 longword and 24-27 unused. Every entry from 28 up takes its code from i mod 4: 0 gives byte, 1 halfword, 2 longword and 3 unused.
- R3: `reqSize` 1/2/3 selects byte/halfword/longword, and 0 is an error. A halfword at an odd offset and a longword at an offset that is not a multiple of 4 are errors.
- R4: Sub-operations are issued in consecutive cycles, starting in the cycle after `reqStart` is sampled. `reqDone` is a single-cycle pulse, N+1 cycles after the start cycle for N sub-operations. An error completes 1 cycle after the start cycle.
- R5: A read narrower than the native width issues one read of the register at the offset aligned to the native width. It returns the addressed bytes, with the lower byte address more significant, right-aligned in `rspRdata`.
- R6: A write narrower than the native width issues a read and then a write of the same register. Only the addressed bytes change.
- R7: An access wider than the native width issues S/N native sub-operations at ascending addresses, S being the access bytes and N the native bytes. The first of them carries or returns the most significant part.
- R8: Each sub-operation has `regSize` equal to the map code of `regAddr`, and `regAddr` is aligned to that width.
- R9: `reqStart` is ignored while an access is in progress or completing. It adds no sub-operation and no extra `reqDone`.
- R10: During reset `reqDone` and `regValid` are low.
- R11: `rspRdata` is zero on completion of writes and of errors. For a valid read it holds the bytes at offset..offset+S-1, most significant first, right-aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqStart | input | 1 | Start an access (sampled only when idle) |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqSize | input | 2 | Access size code: 1 byte, 2 halfword, 3 longword |
| reqAddr | input | 10 | Byte offset in the register window |
| reqWdata | input | 32 | Write data, right-aligned |
| reqDone | output | 1 | One-cycle completion pulse |
| rspErr | output | 1 | Error flag, valid with reqDone |
| rspRdata | output | 32 | Read data, right-aligned, valid with reqDone |
| regValid | output | 1 | Register sub-operation this cycle |
| regWrite | output | 1 | Sub-operation is a write |
| regSize | output | 2 | Native width code of the sub-operation |
| regAddr | output | 10 | Sub-operation offset |
| regWdata | output | 32 | Sub-operation write data, right-aligned |
| regRdata | input | 32 | Register read data, right-aligned, same cycle |

## Verification
The bench keeps a byte-addressed reference image and compares it with a register model that only accepts native-width sub-operations. Every access must therefore look like plain big-endian byte memory, whatever the native width behind it. Randomly mixed sizes and offsets over the whole 10-bit range exercise all nine size-against-width pairings, along with the error paths. Directed accesses separate the three paths. Longword reads of the byte region show the four-piece order. Byte writes into a longword register, followed by a full readback, show that the read-modify-write spares neighbouring bytes. Writes to offsets at 0x200 and above show that nothing is touched. Sub-operation counts and completion latency separate the single, split and merge sequences, and a start pulse issued mid-access shows that such pulses are ignored.

// File: rtl/rwa_pkg.sv
package rwa_pkg;
  localparam int OFF_W   = 10;
  localparam int IDX_LO  = 2;
  localparam int IDX_W   = OFF_W - 1 - IDX_LO;
  localparam int ENTRIES = 1 << IDX_W;
  localparam int MAP_W   = 2 * ENTRIES;
  localparam int DATA_W  = 32;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DONE} phase_t;

  typedef struct packed {
    logic       load;
    logic       issue;
    logic [1:0] step;
  } strobe_t;

  function automatic logic [2:0] byteCount(logic [1:0] code);
    case (code)
      2'd1:    return 3'd1;
      2'd2:    return 3'd2;
      2'd3:    return 3'd4;
      default: return 3'd0;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] laneMask(logic [2:0] nBytes);
    case (nBytes)
      3'd1:    return 32'h0000_00ff;
      3'd2:    return 32'h0000_ffff;
      default: return 32'hffff_ffff;
    endcase
  endfunction

  function automatic logic [MAP_W-1:0] defaultMap();
    logic [MAP_W-1:0] m;
    m = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      logic [1:0] c;
      if (i < 8)       c = 2'd1;
      else if (i < 16) c = 2'd2;
      else if (i < 24) c = 2'd3;
      else if (i < 28) c = 2'd0;
      else             c = ((i % 4) == 3) ? 2'd0 : 2'((i % 4) + 1);
      m[2*i +: 2] = c;
    end
    return m;
  endfunction
endpackage

// File: rtl/rwa_control.sv
module rwa_control
  import rwa_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqStart,
  input  logic       reqErr,
  input  logic [1:0] lastStep,
  output strobe_t    strb,
  output logic       reqDone
);
  phase_t     state, nxt;
  logic [1:0] step;

  always_comb begin
    strb = '0;
    nxt  = state;
    case (state)
      ST_IDLE: if (reqStart) begin
        strb.load = 1'b1;
        nxt = reqErr ? ST_DONE : ST_RUN;
      end
      ST_RUN: begin
        strb.issue = 1'b1;
        strb.step  = step;
        if (step == lastStep) nxt = ST_DONE;
      end
      ST_DONE: nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  assign reqDone = (state == ST_DONE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      step  <= 2'd0;
    end else begin
      state <= nxt;
      step  <= (state == ST_RUN && nxt == ST_RUN) ? step + 2'd1 : 2'd0;
    end
  end

  // R4: completion is a single-cycle pulse
  a_r4_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    reqDone |=> !reqDone);
  // R9: no sub-operation immediately follows completion
  a_r9_quiet_after_done: assert property (@(posedge clk) disable iff (!rstN)
    reqDone |=> !strb.issue);
endmodule

// File: rtl/rwa_datapath.sv
module rwa_datapath
  import rwa_pkg::*;
#(
  parameter logic [MAP_W-1:0] WIDTH_MAP = defaultMap()
)(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic              reqWrite,
  input  logic [1:0]        reqSize,
  input  logic [OFF_W-1:0]  reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              reqErr,
  output logic [1:0]        lastStep,
  output logic              errHeld,
  output logic [DATA_W-1:0] rspRdata,
  output logic              regValid,
  output logic              regWrite,
  output logic [1:0]        regSize,
  output logic [OFF_W-1:0]  regAddr,
  output logic [DATA_W-1:0] regWdata,
  input  logic [DATA_W-1:0] regRdata
);
  // request decode
  logic [1:0] natIn;
  logic       misal;
  assign natIn  = WIDTH_MAP[{reqAddr[OFF_W-2:IDX_LO], 1'b0} +: 2];
  assign misal  = (reqSize == 2'd2 && reqAddr[0]) ||
                  (reqSize == 2'd3 && reqAddr[1:0] != 2'd0);
  assign reqErr = reqAddr[OFF_W-1] || reqSize == 2'd0 || natIn == 2'd0 || misal;

  // latched access
  logic [OFF_W-1:0]  aOff;
  logic [1:0]        aSize, aNat;
  logic              aWrite;
  logic [DATA_W-1:0] aWdata, acc;

  logic              split, widen;
  logic [2:0]        nB, sB, lane, stepOff, laneByte, pieceByte;
  logic [1:0]        natShift;
  logic [5:0]        laneShift, pieceShift;
  logic [DATA_W-1:0] natMask, accMask;
  logic [OFF_W-1:0]  alignMask;

  assign split      = aNat < aSize;
  assign widen      = aNat > aSize;
  assign nB         = byteCount(aNat);
  assign sB         = byteCount(aSize);
  assign natMask    = laneMask(nB);
  assign accMask    = laneMask(sB);
  assign natShift   = aNat - 2'd1;
  assign stepOff    = {1'b0, strb.step} << natShift;
  assign lane       = aOff[2:0] & (nB - 3'd1);
  assign laneByte   = nB - lane - sB;
  assign laneShift  = {laneByte, 3'b000};
  assign pieceByte  = sB - nB - stepOff;
  assign pieceShift = {pieceByte, 3'b000};
  assign alignMask  = ~{{(OFF_W-3){1'b0}}, nB - 3'd1};

  assign lastStep = split ? (((aSize - aNat) == 2'd1) ? 2'd1 : 2'd3)
                          : ((widen && aWrite) ? 2'd1 : 2'd0);

  // register-side sub-operation
  assign regValid = strb.issue;
  assign regSize  = aNat;
  assign regWrite = aWrite && (!widen || strb.step == 2'd1);
  assign regAddr  = split ? aOff + {{(OFF_W-3){1'b0}}, stepOff} : (aOff & alignMask);

  always_comb begin
    if (split)
      regWdata = (aWdata >> pieceShift) & natMask;
    else if (widen)
      regWdata = (acc & ~(accMask << laneShift)) | ((aWdata & accMask) << laneShift);
    else
      regWdata = aWdata & natMask;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      aOff    <= '0;
      aSize   <= 2'd0;
      aNat    <= 2'd0;
      aWrite  <= 1'b0;
      aWdata  <= '0;
      errHeld <= 1'b0;
      acc     <= '0;
    end else if (strb.load) begin
      aOff    <= reqAddr;
      aSize   <= reqSize;
      aNat    <= natIn;
      aWrite  <= reqWrite;
      aWdata  <= reqWdata;
      errHeld <= reqErr;
      acc     <= '0;
    end else if (strb.issue && !regWrite) begin
      if (split) acc <= (acc << {nB, 3'b000}) | (regRdata & natMask);
      else       acc <= regRdata & natMask;
    end
  end

  assign rspRdata = (errHeld || aWrite) ? '0
                  : (widen ? ((acc >> laneShift) & accMask) : acc);

  // R1: a rejected access never reaches the register port
  a_r1_err_no_subop: assert property (@(posedge clk) disable iff (!rstN)
    strb.issue |-> !errHeld);
  // R8: every sub-operation matches the map width at its own address
  a_r8_native_lookup: assert property (@(posedge clk) disable iff (!rstN)
    regValid |-> (WIDTH_MAP[{regAddr[OFF_W-2:IDX_LO], 1'b0} +: 2] == regSize) && !regAddr[OFF_W-1]);
  // R6: a merge write follows a read of the same register
  a_r6_read_before_write: assert property (@(posedge clk) disable iff (!rstN)
    (regValid && regWrite && widen) |-> $past(regValid) && !$past(regWrite) && $past(regAddr) == regAddr);
endmodule

// File: rtl/reg_width_adapter.sv
module reg_width_adapter
  import rwa_pkg::*;
#(
  parameter logic [MAP_W-1:0] WIDTH_MAP = defaultMap()
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqStart,
  input  logic              reqWrite,
  input  logic [1:0]        reqSize,
  input  logic [OFF_W-1:0]  reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              reqDone,
  output logic              rspErr,
  output logic [DATA_W-1:0] rspRdata,
  output logic              regValid,
  output logic              regWrite,
  output logic [1:0]        regSize,
  output logic [OFF_W-1:0]  regAddr,
  output logic [DATA_W-1:0] regWdata,
  input  logic [DATA_W-1:0] regRdata
);
  strobe_t    strb;
  logic       reqErr;
  logic [1:0] lastStep;

  rwa_control ctl_i (
    .clk(clk), .rstN(rstN), .reqStart(reqStart), .reqErr(reqErr),
    .lastStep(lastStep), .strb(strb), .reqDone(reqDone)
  );

  rwa_datapath #(.WIDTH_MAP(WIDTH_MAP)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .reqWrite(reqWrite),
    .reqSize(reqSize), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .reqErr(reqErr), .lastStep(lastStep), .errHeld(rspErr),
    .rspRdata(rspRdata), .regValid(regValid), .regWrite(regWrite),
    .regSize(regSize), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata)
  );
endmodule

// File: tb/reg_width_adapter_tb_top.sv
module reg_width_adapter_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqStart = 1'b0, reqWrite = 1'b0;
  logic [1:0]  reqSize = 2'd0;
  logic [9:0]  reqAddr = '0;
  logic [31:0] reqWdata = '0;
  logic        reqDone, rspErr, regValid, regWrite;
  logic [31:0] rspRdata, regWdata, regRdata;
  logic [1:0]  regSize;
  logic [9:0]  regAddr;

  int checks = 0, errors = 0, subOps = 0;
  bit finished = 0;
  logic [7:0] mem  [0:511];
  logic [7:0] refm [0:511];

  always #10 clk = ~clk;

  reg_width_adapter dut_i (
    .clk(clk), .rstN(rstN), .reqStart(reqStart), .reqWrite(reqWrite),
    .reqSize(reqSize), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .reqDone(reqDone), .rspErr(rspErr), .rspRdata(rspRdata),
    .regValid(regValid), .regWrite(regWrite), .regSize(regSize),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata)
  );

  function automatic int mapCode(int idx);
    if (idx < 8)  return 1;
    if (idx < 16) return 2;
    if (idx < 24) return 3;
    if (idx < 28) return 0;
    return ((idx % 4) == 3) ? 0 : (idx % 4) + 1;
  endfunction

  function automatic int nBytes(int code);
    return (code == 3) ? 4 : code;
  endfunction

  function automatic bit expErr(int size, int off);
    if (off >= 512 || size == 0) return 1;
    if (size == 2 && (off % 2) != 0) return 1;
    if (size == 3 && (off % 4) != 0) return 1;
    return mapCode(off / 4) == 0;
  endfunction

  function automatic int expSteps(int size, int nat, bit wr);
    if (nat < size) return nBytes(size) / nBytes(nat);
    if (nat > size && wr) return 2;
    return 1;
  endfunction

  // register model: native-width, big-endian bytes
  always_comb begin
    int a;
    a = int'(regAddr[8:0]);
    if (a > 508) a = 508;
    case (regSize)
      2'd1:    regRdata = {24'h0, mem[a]};
      2'd2:    regRdata = {16'h0, mem[a], mem[a+1]};
      default: regRdata = {mem[a], mem[a+1], mem[a+2], mem[a+3]};
    endcase
  end

  always @(posedge clk) begin
    if (regValid && regWrite) begin
      int a;
      a = int'(regAddr[8:0]);
      case (regSize)
        2'd1: mem[a] <= regWdata[7:0];
        2'd2: begin mem[a] <= regWdata[15:8]; mem[a+1] <= regWdata[7:0]; end
        default: if (a <= 508) begin
          mem[a] <= regWdata[31:24]; mem[a+1] <= regWdata[23:16];
          mem[a+2] <= regWdata[15:8]; mem[a+3] <= regWdata[7:0];
        end
      endcase
    end
  end

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // R8 legality of every sub-operation, sampled away from the edge
  always @(negedge clk) begin
    if (rstN && regValid) begin
      int code;
      code = mapCode(int'(regAddr[8:2]));
      subOps++;
      chk(regSize == 2'(code) && !regAddr[9], "R8 size", {30'h0, regSize}, code);
      chk((int'(regAddr) % nBytes(code)) == 0, "R8 align", {22'h0, regAddr}, 0);
    end
  end

  task automatic doAccess(bit wr, int size, int addr, logic [31:0] wd, bit poke);
    int off, cnt, startOps, nat, steps, s;
    bit e;
    logic [31:0] expv;
    off = addr & 10'h3ff;
    e = expErr(size, off);
    nat = e ? 0 : mapCode((off / 4) % 128);
    steps = e ? 0 : expSteps(size, nat, wr);
    s = nBytes(size);
    expv = 0;
    if (!e && !wr) for (int i = 0; i < s; i++) expv = (expv << 8) | refm[off+i];
    @(negedge clk);
    reqWrite = wr; reqSize = 2'(size); reqAddr = 10'(off); reqWdata = wd; reqStart = 1'b1;
    startOps = subOps;
    cnt = 0;
    do begin
      @(negedge clk);
      cnt++;
      if (poke && cnt == 1) begin reqStart = 1'b1; reqAddr = 10'h3c1; end
      else reqStart = 1'b0;
    end while (!reqDone && cnt < 50);
    reqStart = 1'b0;
    chk(cnt == steps + 1, "R4 latency", cnt, steps + 1);
    chk(rspErr == e, e ? "R1/R2/R3 error flag" : "R3 no error", {31'h0, rspErr}, {31'h0, e});
    chk(subOps - startOps == steps, "R7/R6 sub-op count", subOps - startOps, steps);
    chk(rspRdata == expv, "R11 read data (R5/R7)", rspRdata, expv);
    if (!e && wr)
      for (int i = 0; i < s; i++) refm[off+i] = 8'(wd >> (8*(s-1-i)));
    if (poke) begin
      @(negedge clk);
      chk(!reqDone && subOps - startOps == steps, "R9 start ignored", {31'h0, reqDone}, 0);
    end
  endtask

  initial begin
    for (int i = 0; i < 512; i++) begin mem[i] = 8'((i*7 + 3) & 255); refm[i] = mem[i]; end
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    chk(!reqDone && !regValid, "R10 reset state", {30'h0, reqDone, regValid}, 0);
    rstN = 1'b1;
    doAccess(0, 3, 10'h004, 0, 0);             // R7 four byte pieces
    doAccess(0, 3, 10'h028, 0, 0);             // R7 two halfword pieces
    doAccess(0, 2, 10'h022, 0, 0);             // R4 same width
    doAccess(0, 1, 10'h043, 0, 0);             // R5 byte lane of a longword
    doAccess(0, 2, 10'h046, 0, 0);             // R5 lower half of a longword
    doAccess(1, 1, 10'h041, 32'ha5, 0);        // R6 byte merge
    doAccess(0, 3, 10'h040, 0, 0);             // R6 neighbours intact
    doAccess(1, 2, 10'h044, 32'hbeef, 0);      // R6 upper half merge
    doAccess(0, 3, 10'h044, 0, 0);
    doAccess(1, 3, 10'h024, 32'h1234_5678, 0); // R7 split write
    doAccess(0, 1, 10'h025, 0, 0);             // R5 byte of a halfword
    doAccess(1, 3, 10'h008, 32'hcafe_f00d, 0); // R7 four byte writes
    doAccess(0, 3, 10'h008, 0, 0);
    doAccess(0, 3, 10'h060, 0, 0);             // R2 unused entry
    doAccess(0, 1, 10'h07d, 0, 0);             // R2 unused entry above 28
    doAccess(0, 1, 10'h200, 0, 0);             // R1 out of window
    doAccess(1, 1, 10'h201, 32'h77, 0);        // R1 write ignored
    doAccess(0, 1, 10'h001, 0, 0);             // R1 location unchanged
    doAccess(0, 2, 10'h021, 0, 0);             // R3 misaligned halfword
    doAccess(0, 0, 10'h000, 0, 0);             // R3 size code 0
    doAccess(0, 3, 10'h00c, 0, 1);             // R9 start during access
    for (int n = 0; n < 400; n++) begin
      int sz, ad;
      sz = int'($urandom % 4);
      ad = int'($urandom % 1024);
      if (($urandom % 5) != 0 && sz > 1) ad = ad & ((sz == 3) ? ~3 : ~1);
      doAccess(1'($urandom % 2), sz, ad, $urandom, 0);
    end
    for (int i = 0; i < 512; i++)
      if (mem[i] != refm[i]) chk(0, "R6 image", {24'h0, mem[i]}, {24'h0, refm[i]});
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule